// File: doc/BRIEF.md
# FMA Special-Operand Resolver

This block sits in front of a double-precision fused multiply-add datapath that computes d = z + x*y. For each operation it receives the class of x, y and z, their signs and their raw 64-bit encodings. It decides whether the result is fixed by special operands (NaNs, infinities, zero products) and can bypass the arithmetic. When no bypass applies, it tells the datapath to compute and reports which operands are subnormal and must be normalised first.

The decision is made combinationally from the inputs and held in a decision register, which acts as the block's state. One cycle after an accepted operation the registered decision drives the outputs. The decision states are:
- IDLE: no result is pending.
- Z_SNAN, X_SNAN, Y_SNAN: quiet the named signalling NaN and return it.
- X_QNAN, Y_QNAN: pass the named quiet NaN through.
- PASS_Z: return the addend unchanged.
- INVALID: return the default NaN.
- PROD_INF: return an infinity signed by the product.
- ADDEND_INF: return an infinity signed by the addend.
- PROCEED: hand the operation to the datapath.

Every cycle the next state is IDLE when `in_valid` is low, and otherwise the state chosen by the precedence below. Reset enters IDLE.

Top module: `fma_sp_resolver`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 subnormal, 3 infinity, 4 quiet NaN, 5 signalling NaN. An operation presented with `in_valid` high at a clock edge has its outputs on the next cycle with `out_valid` high. After reset, or after a cycle with `in_valid` low, every output is zero.
- R2: A signalling-NaN z takes precedence over every x and y combination. It sets `invalid` and returns quieted z.
- R3: Otherwise, a signalling-NaN x returns quieted x whatever y is. A signalling-NaN y with a non-signalling x returns quieted y. Both cases set `invalid`.
- R4: Quieting sets bit 51 of the encoding and keeps the sign, the exponent and all other payload bits.
- R5: With no signalling NaN present, a quiet-NaN x is returned unchanged even if y or z is also a quiet NaN. A quiet-NaN y is returned unchanged when x is not a NaN. Neither case sets `invalid`.
- R6: Infinity times zero, in either order, returns z when z is a quiet NaN. Otherwise it sets `invalid` and returns the default NaN 0x7FF8000000000000.
- R7: Infinity times a non-zero finite value or infinity returns z when z is a quiet NaN. If z is an infinity whose sign differs from xs XOR ys, it sets `invalid` and returns the default NaN. Otherwise it returns an infinity with sign xs XOR ys.
- R8: A zero product returns an infinity carrying z's sign when z is infinite. Otherwise it returns z unchanged.
- R9: When both factors are finite and non-zero, a quiet-NaN z is returned unchanged and an infinite z returns an infinity with z's sign. Otherwise `proceed` is high, `byp_valid` is low and `byp_result` is zero.
- R10: `sub_flags` bit 0, 1 and 2 mark x, y and z as subnormal. They are driven only while `proceed` is high and are zero otherwise.
- R11: While `out_valid` is high, exactly one of `byp_valid` and `proceed` is high. `invalid` is never high without `byp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| x_cls | input | 3 | Class code of multiplicand x |
| y_cls | input | 3 | Class code of multiplier y |
| z_cls | input | 3 | Class code of addend z |
| x_sign | input | 1 | Sign of x |
| y_sign | input | 1 | Sign of y |
| z_sign | input | 1 | Sign of z |
| x_raw | input | 64 | Encoding of x |
| y_raw | input | 64 | Encoding of y |
| z_raw | input | 64 | Encoding of z |
| out_valid | output | 1 | Decision outputs are valid |
| byp_valid | output | 1 | Special result replaces the datapath result |
| byp_result | output | 64 | Special result encoding |
| invalid | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Datapath must compute the result |
| sub_flags | output | 3 | Subnormal operands needing normalisation (bit0 x, bit1 y, bit2 z) |

## Verification
The bench targets the precedence corners. The first is an addend signalling NaN paired with an infinity-times-zero product: a design that examines the factors first would return the default NaN instead of quieted z. The second is a quiet-NaN x next to a quiet-NaN y and a quiet-NaN z: a swapped priority would return the wrong payload. The third is an infinite product against an infinite addend of equal and of opposite sign: getting this wrong either drops the invalid flag or wrongly raises it. Negative signalling NaNs check that quieting keeps sign and payload. Subnormal flags are checked both on a proceed case and on a bypass case, where they must stay low.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO  = 3'd0,
        CLS_NORM  = 3'd1,
        CLS_SUB   = 3'd2,
        CLS_INF   = 3'd3,
        CLS_QNAN  = 3'd4,
        CLS_SNAN  = 3'd5
    } fma_cls_e;

    typedef enum logic [3:0] {
        DEC_IDLE,
        DEC_Z_SNAN,
        DEC_X_SNAN,
        DEC_Y_SNAN,
        DEC_X_QNAN,
        DEC_Y_QNAN,
        DEC_PASS_Z,
        DEC_INVALID,
        DEC_PROD_INF,
        DEC_ADDEND_INF,
        DEC_PROCEED
    } fma_dec_e;

    localparam int NUM_OPS = 3;

endpackage

// File: rtl/fma_nan_quiet.sv
module fma_nan_quiet #(
    parameter int W     = 64,
    parameter int QUIET = 51
) (
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] quiet_out
);
    localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QUIET;

    // Quieting only forces the leading fraction bit, all else is kept.
    always_comb begin
        quiet_out = raw_in | QMASK;
    end
endmodule

// File: rtl/fma_sp_decide.sv
module fma_sp_decide
    import fma_sp_pkg::*;
(
    input  logic [2:0] cx,
    input  logic [2:0] cy,
    input  logic [2:0] cz,
    input  logic       xs,
    input  logic       ys,
    input  logic       zs,
    output fma_dec_e   dec
);
    fma_cls_e kx, ky, kz;
    logic     prod_sign;
    logic     inf_zero;
    logic     any_inf;
    logic     any_zero;

    always_comb begin
        kx        = fma_cls_e'(cx);
        ky        = fma_cls_e'(cy);
        kz        = fma_cls_e'(cz);
        prod_sign = xs ^ ys;
        inf_zero  = (kx == CLS_INF && ky == CLS_ZERO) ||
                    (kx == CLS_ZERO && ky == CLS_INF);
        any_inf   = (kx == CLS_INF) || (ky == CLS_INF);
        any_zero  = (kx == CLS_ZERO) || (ky == CLS_ZERO);
    end

    // Fixed precedence: addend sNaN, factor sNaNs, factor qNaNs,
    // then product classes with the addend as tie-breaker.
    always_comb begin
        dec = DEC_PROCEED;
        if (kz == CLS_SNAN) begin
            dec = DEC_Z_SNAN;
        end else if (kx == CLS_SNAN) begin
            dec = DEC_X_SNAN;
        end else if (ky == CLS_SNAN) begin
            dec = DEC_Y_SNAN;
        end else if (kx == CLS_QNAN) begin
            dec = DEC_X_QNAN;
        end else if (ky == CLS_QNAN) begin
            dec = DEC_Y_QNAN;
        end else if (inf_zero) begin
            dec = (kz == CLS_QNAN) ? DEC_PASS_Z : DEC_INVALID;
        end else if (any_inf) begin
            if (kz == CLS_QNAN)
                dec = DEC_PASS_Z;
            else if (kz == CLS_INF && zs != prod_sign)
                dec = DEC_INVALID;
            else
                dec = DEC_PROD_INF;
        end else if (any_zero) begin
            dec = (kz == CLS_INF) ? DEC_ADDEND_INF : DEC_PASS_Z;
        end else if (kz == CLS_QNAN) begin
            dec = DEC_PASS_Z;
        end else if (kz == CLS_INF) begin
            dec = DEC_ADDEND_INF;
        end
    end
endmodule

// File: rtl/fma_sp_resolver.sv
module fma_sp_resolver
    import fma_sp_pkg::*;
#(
    parameter int          W           = 64,
    parameter int          EXP_W       = 11,
    parameter int          QUIET_BIT   = 51,
    parameter logic [63:0] DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    x_cls,
    input  logic [2:0]    y_cls,
    input  logic [2:0]    z_cls,
    input  logic          x_sign,
    input  logic          y_sign,
    input  logic          z_sign,
    input  logic [W-1:0]  x_raw,
    input  logic [W-1:0]  y_raw,
    input  logic [W-1:0]  z_raw,
    output logic          out_valid,
    output logic          byp_valid,
    output logic [W-1:0]  byp_result,
    output logic          invalid,
    output logic          proceed,
    output logic [NUM_OPS-1:0] sub_flags
);
    localparam int FRAC_W = W - 1 - EXP_W;
    localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QUIET_BIT;

    fma_dec_e          dec_d, dec_q;
    logic [W-1:0]      op_q   [NUM_OPS];
    logic [W-1:0]      op_qn  [NUM_OPS];
    logic [NUM_OPS-1:0] sub_q;
    logic              prod_sign_q;
    logic              z_sign_q;
    logic [W-1:0]      inf_prod;
    logic [W-1:0]      inf_add;

    fma_sp_decide u_decide (
        .cx  (x_cls),
        .cy  (y_cls),
        .cz  (z_cls),
        .xs  (x_sign),
        .ys  (y_sign),
        .zs  (z_sign),
        .dec (dec_d)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_OPS; g++) begin : g_quiet
            fma_nan_quiet #(.W(W), .QUIET(QUIET_BIT)) u_quiet (
                .raw_in    (op_q[g]),
                .quiet_out (op_qn[g])
            );
        end
    endgenerate

    // State register: decision and the operand context it needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q       <= DEC_IDLE;
            sub_q       <= '0;
            prod_sign_q <= 1'b0;
            z_sign_q    <= 1'b0;
            for (int i = 0; i < NUM_OPS; i++) op_q[i] <= '0;
        end else begin
            dec_q <= in_valid ? dec_d : DEC_IDLE;
            if (in_valid) begin
                op_q[0]     <= x_raw;
                op_q[1]     <= y_raw;
                op_q[2]     <= z_raw;
                sub_q       <= {z_cls == CLS_SUB, y_cls == CLS_SUB, x_cls == CLS_SUB};
                prod_sign_q <= x_sign ^ y_sign;
                z_sign_q    <= z_sign;
            end
        end
    end

    always_comb begin
        inf_prod = {prod_sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        inf_add  = {z_sign_q,    {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end

    // Output process driven only by the registered state.
    always_comb begin
        out_valid  = 1'b1;
        byp_valid  = 1'b1;
        byp_result = '0;
        invalid    = 1'b0;
        proceed    = 1'b0;
        sub_flags  = '0;
        unique case (dec_q)
            DEC_IDLE: begin
                out_valid = 1'b0;
                byp_valid = 1'b0;
            end
            DEC_Z_SNAN: begin
                byp_result = op_qn[2];
                invalid    = 1'b1;
            end
            DEC_X_SNAN: begin
                byp_result = op_qn[0];
                invalid    = 1'b1;
            end
            DEC_Y_SNAN: begin
                byp_result = op_qn[1];
                invalid    = 1'b1;
            end
            DEC_X_QNAN:     byp_result = op_q[0];
            DEC_Y_QNAN:     byp_result = op_q[1];
            DEC_PASS_Z:     byp_result = op_q[2];
            DEC_INVALID: begin
                byp_result = DEFAULT_NAN[W-1:0];
                invalid    = 1'b1;
            end
            DEC_PROD_INF:   byp_result = inf_prod;
            DEC_ADDEND_INF: byp_result = inf_add;
            DEC_PROCEED: begin
                byp_valid = 1'b0;
                proceed   = 1'b1;
                sub_flags = sub_q;
            end
            default: begin
                out_valid = 1'b0;
                byp_valid = 1'b0;
            end
        endcase
    end

    // R11
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({byp_valid, proceed}) == 1));

    // R11
    inv_needs_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> byp_valid);

    // R1
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    z_snan_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_cls == 3'd5) |=>
            (invalid && byp_result == ($past(z_raw) | QMASK)));

    // R10
    sub_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sub_flags) |-> proceed);

endmodule

// File: tb/sim_fma_sp_resolver.sv
module sim_fma_sp_resolver;

    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] PZERO = 64'h0;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] QNA   = 64'h7FF8_0000_0000_0123;
    localparam logic [63:0] QNB   = 64'hFFF8_0000_0000_0ABC;
    localparam logic [63:0] QNC   = 64'h7FF8_0000_0000_0777;
    localparam logic [63:0] SNA   = 64'h7FF0_0000_0000_0456;
    localparam logic [63:0] SNB   = 64'hFFF0_0000_0000_0789;
    localparam logic [63:0] SNC   = 64'h7FF0_0000_0000_0011;
    localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] DNAN  = 64'h7FF8_0000_0000_0000;

    localparam logic [2:0] C_ZERO = 3'd0, C_NORM = 3'd1, C_SUB = 3'd2,
                           C_INF = 3'd3, C_QNAN = 3'd4, C_SNAN = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  x_cls = '0, y_cls = '0, z_cls = '0;
    logic        x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
    logic [63:0] x_raw = '0, y_raw = '0, z_raw = '0;
    logic        out_valid, byp_valid, invalid, proceed;
    logic [63:0] byp_result;
    logic [2:0]  sub_flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fma_sp_resolver u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_cls(x_cls), .y_cls(y_cls), .z_cls(z_cls),
        .x_sign(x_sign), .y_sign(y_sign), .z_sign(z_sign),
        .x_raw(x_raw), .y_raw(y_raw), .z_raw(z_raw),
        .out_valid(out_valid), .byp_valid(byp_valid), .byp_result(byp_result),
        .invalid(invalid), .proceed(proceed), .sub_flags(sub_flags)
    );

    task automatic check(input string tag, input logic ev, input logic ebv,
                         input logic [63:0] eres, input logic einv,
                         input logic epro, input logic [2:0] esub);
        n_tests++;
        if (out_valid !== ev || byp_valid !== ebv || byp_result !== eres ||
            invalid !== einv || proceed !== epro || sub_flags !== esub) begin
            n_fail++;
            $display("FAIL %s: got v=%b bv=%b res=%h inv=%b pro=%b sub=%b exp v=%b bv=%b res=%h inv=%b pro=%b sub=%b",
                     tag, out_valid, byp_valid, byp_result, invalid, proceed, sub_flags,
                     ev, ebv, eres, einv, epro, esub);
        end
        // R11 on every observed result
        n_tests++;
        if (out_valid && (byp_valid == proceed || (invalid && !byp_valid))) begin
            n_fail++;
            $display("FAIL R11 %s: got bv=%b pro=%b inv=%b exp one path", tag,
                     byp_valid, proceed, invalid);
        end
    endtask

    // Drive at negedge, sample 1 ns after the capturing posedge.
    task automatic apply(input logic [2:0] cx, input logic [63:0] x,
                         input logic [2:0] cy, input logic [63:0] y,
                         input logic [2:0] cz, input logic [63:0] z);
        @(negedge clk);
        in_valid = 1'b1;
        x_cls = cx; y_cls = cy; z_cls = cz;
        x_raw = x;  y_raw = y;  z_raw = z;
        x_sign = x[63]; y_sign = y[63]; z_sign = z[63];
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic byp(input string tag, input logic [63:0] eres, input logic einv);
        check(tag, 1'b1, 1'b1, eres, einv, 1'b0, 3'b000);
    endtask

    task automatic t_reset;
        check("R1 reset", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 3'b000);
    endtask

    task automatic t_idle;
        apply(C_NORM, ONE, C_NORM, ONE, C_NORM, ONE);
        @(posedge clk); #1;
        check("R1 idle after op", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 3'b000);
    endtask

    task automatic t_z_snan;
        apply(C_SNAN, SNA, C_SNAN, SNB, C_SNAN, SNC);
        byp("R2 z sNaN over x,y sNaN", 64'h7FF8_0000_0000_0011, 1'b1);
        apply(C_INF, PINF, C_ZERO, PZERO, C_SNAN, SNB);
        byp("R2 z sNaN over inf*0 (R4 sign kept)", 64'hFFF8_0000_0000_0789, 1'b1);
    endtask

    task automatic t_factor_snan;
        apply(C_SNAN, SNA, C_QNAN, QNA, C_QNAN, QNC);
        byp("R3 x sNaN with y qNaN", 64'h7FF8_0000_0000_0456, 1'b1);
        apply(C_SNAN, SNA, C_SNAN, SNB, C_NORM, ONE);
        byp("R3 x sNaN with y sNaN", 64'h7FF8_0000_0000_0456, 1'b1);
        apply(C_QNAN, QNA, C_SNAN, SNB, C_NORM, ONE);
        byp("R3 y sNaN over x qNaN (R4 quieting)", 64'hFFF8_0000_0000_0789, 1'b1);
    endtask

    task automatic t_qnan;
        apply(C_QNAN, QNB, C_QNAN, QNA, C_QNAN, QNC);
        byp("R5 x qNaN over y,z qNaN", QNB, 1'b0);
        apply(C_NORM, ONE, C_QNAN, QNA, C_QNAN, QNC);
        byp("R5 y qNaN when x not NaN", QNA, 1'b0);
    endtask

    task automatic t_inf_zero;
        apply(C_INF, PINF, C_ZERO, NZERO, C_NORM, ONE);
        byp("R6 inf*0 default NaN", DNAN, 1'b1);
        apply(C_ZERO, PZERO, C_INF, NINF, C_QNAN, QNC);
        byp("R6 0*inf with qNaN z", QNC, 1'b0);
    endtask

    task automatic t_inf_prod;
        apply(C_INF, PINF, C_NORM, MTWO, C_NORM, ONE);
        byp("R7 +inf*-2 gives -inf", NINF, 1'b0);
        apply(C_INF, PINF, C_NORM, MTWO, C_INF, NINF);
        byp("R7 -inf product plus -inf", NINF, 1'b0);
        apply(C_INF, PINF, C_NORM, MTWO, C_INF, PINF);
        byp("R7 -inf product plus +inf invalid", DNAN, 1'b1);
        apply(C_INF, NINF, C_INF, NINF, C_QNAN, QNA);
        byp("R7 inf*inf with qNaN z", QNA, 1'b0);
        apply(C_SUB, SUBN, C_INF, NINF, C_ZERO, PZERO);
        byp("R7 sub*-inf gives -inf", NINF, 1'b0);
    endtask

    task automatic t_zero_prod;
        apply(C_ZERO, PZERO, C_NORM, ONE, C_INF, NINF);
        byp("R8 zero product plus -inf", NINF, 1'b0);
        apply(C_NORM, MTWO, C_ZERO, PZERO, C_NORM, ONE);
        byp("R8 zero product returns z", ONE, 1'b0);
        apply(C_ZERO, NZERO, C_SUB, SUBN, C_ZERO, NZERO);
        byp("R8 zero product returns -0 z", NZERO, 1'b0);
    endtask

    task automatic t_finite;
        apply(C_NORM, ONE, C_NORM, MTWO, C_QNAN, QNB);
        byp("R9 finite product qNaN z", QNB, 1'b0);
        apply(C_NORM, ONE, C_NORM, MTWO, C_INF, PINF);
        byp("R9 finite product +inf z", PINF, 1'b0);
        apply(C_NORM, ONE, C_NORM, MTWO, C_NORM, ONE);
        check("R9 proceed", 1'b1, 1'b0, 64'h0, 1'b0, 1'b1, 3'b000);
        apply(C_SUB, SUBN, C_NORM, ONE, C_SUB, SUBN);
        check("R10 x,z subnormal flags", 1'b1, 1'b0, 64'h0, 1'b0, 1'b1, 3'b101);
        apply(C_NORM, ONE, C_SUB, SUBN, C_NORM, ONE);
        check("R10 y subnormal flag", 1'b1, 1'b0, 64'h0, 1'b0, 1'b1, 3'b010);
        apply(C_SUB, SUBN, C_SUB, SUBN, C_INF, NINF);
        byp("R10 flags low on bypass", NINF, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_z_snan();
        t_factor_snan();
        t_qnan();
        t_inf_zero();
        t_inf_prod();
        t_zero_prod();
        t_finite();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule